// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block transfers 8-bit words between two buses, called A and B. Each bus appears as three vectors: the value seen on the bus (input), the value the block would drive (output) and a drive enable. The chip-level wrapper resolves these into a shared wire. Each direction has one storage register. The A-to-B register samples bus A and the B-to-A register samples bus B. A register captures on the rising edge of its own capture strobe. A single system clock samples both strobes.

For each direction a select input picks what the block drives: the live word from the opposite bus, or the word held in that direction's register. Bus B is enabled by an active-high input and bus A by an active-low input. A parameter chooses a true or an inverting data path. The inverting path complements the word on output only. Data, selects and enables are retimed through the same output register. A change of select therefore moves the driven word from the old source to the new one in a single clock step.

Each capture strobe runs through a two-state machine. In STB_LOW the strobe was last sampled low. In STB_HIGH it was last sampled high. The transition ARM (STB_HIGH to STB_LOW) happens when the strobe is sampled low. The transition FIRE (STB_LOW to STB_HIGH) happens when the strobe is sampled high, and in that same cycle it loads the register.

Top module: `reg_xcvr`

## Requirements
- R1: After the synchronous active-low reset, both registers hold 0x00, both drive enables are 0 and both output words are 0x00.
- R2: On the clock edge where a strobe is sampled high after being sampled low on the previous edge, the register of that direction loads its source bus. A strobe held high loads nothing more until it has been sampled low again.
- R3: A capture takes place whatever the values of the selects and the drive enables.
- R4: `to_b_en`=1 drives bus B and `to_a_en_n`=0 drives bus A, one clock after the input is applied. While a direction is disabled, its enable output is 0 and its data output is 0x00.
- R5: With a select at 0, the driven word is the opposite bus as sampled on the previous clock edge. With the select at 1, the driven word is that direction's stored word.
- R6: With both enables active and both selects at 1, the stored A word drives bus B and the stored B word drives bus A in the same cycle.
- R7: A change of select moves the output from the old source to the new source in one clock step, with no other value in between.
- R8: With INVERT=1, every driven word is the bitwise complement of the word that INVERT=0 would drive. Register contents are stored uncomplemented.
- R9: With both directions enabled and in live mode, once an external source stops driving a bus, both buses keep their last value.
- R10: Strobe edges on both directions in the same clock cycle update both registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | 8 | Value seen on bus A |
| a_out | output | 8 | Word the block drives onto bus A |
| a_oe | output | 1 | Drive enable for bus A |
| b_in | input | 8 | Value seen on bus B |
| b_out | output | 8 | Word the block drives onto bus B |
| b_oe | output | 1 | Drive enable for bus B |
| cap_ab | input | 1 | Capture strobe for the A-to-B register |
| cap_ba | input | 1 | Capture strobe for the B-to-A register |
| to_b_en | input | 1 | Active-high enable for driving bus B |
| to_a_en_n | input | 1 | Active-low enable for driving bus A |
| pick_ab | input | 1 | 0: live A to B, 1: stored A to B |
| pick_ba | input | 1 | 0: live B to A, 1: stored B to A |

## Verification
The fault cases are a strobe state machine stuck in STB_HIGH, which would miss every later capture, and one stuck in STB_LOW, which would capture again while the strobe is held high. Each fault shows up as a wrong stored word on the bus two clocks after the strobe edge, as soon as that direction is set to stored mode. A register that fails to hold shows the wrong word in the first stored-mode read. A swapped or inverted enable shows at the enable outputs one clock after the control is applied. A mux that passes through a wrong intermediate value shows in the cycle right after the select changes.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic {
        STB_LOW  = 1'b0,
        STB_HIGH = 1'b1
    } strobe_state_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge
    import xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic fire
);
    strobe_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= STB_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            STB_LOW: begin
                if (strobe) begin
                    state_d = STB_HIGH;   // FIRE
                    fire    = 1'b1;
                end
            end
            STB_HIGH: begin
                if (!strobe) state_d = STB_LOW;  // ARM
            end
        endcase
    end

    // R2: a single strobe edge loads at most once
    p_single_fire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
endmodule

// File: rtl/xfer_lane.sv
module xfer_lane #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] src,
    input  logic         pick,
    input  logic         en,
    output logic [W-1:0] out_d,
    output logic         out_oe
);
    localparam logic [W-1:0] FLIP = INVERT ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] store_q;
    logic [W-1:0] chosen;

    always_ff @(posedge clk) begin
        if (!rst_n)   store_q <= '0;
        else if (cap) store_q <= src;
    end

    always_comb begin
        chosen = pick ? store_q : src;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_d  <= '0;
            out_oe <= 1'b0;
        end else begin
            out_oe <= en;
            out_d  <= en ? (chosen ^ FLIP) : '0;
        end
    end

    // R2: the register holds between captures
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> $stable(store_q));
    // R4: a disabled direction drives no data
    p_isolate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_oe |-> (out_d == '0));
endmodule

// File: rtl/reg_xcvr.sv
module reg_xcvr #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic         to_b_en,
    input  logic         to_a_en_n,
    input  logic         pick_ab,
    input  logic         pick_ba
);
    localparam logic [W-1:0] FLIP = INVERT ? {W{1'b1}} : {W{1'b0}};

    logic fire_ab, fire_ba;

    strobe_edge u_edge_ab (.clk(clk), .rst_n(rst_n), .strobe(cap_ab), .fire(fire_ab));
    strobe_edge u_edge_ba (.clk(clk), .rst_n(rst_n), .strobe(cap_ba), .fire(fire_ba));

    xfer_lane #(.W(W), .INVERT(INVERT)) u_lane_ab (
        .clk(clk), .rst_n(rst_n), .cap(fire_ab), .src(a_in),
        .pick(pick_ab), .en(to_b_en), .out_d(b_out), .out_oe(b_oe)
    );

    xfer_lane #(.W(W), .INVERT(INVERT)) u_lane_ba (
        .clk(clk), .rst_n(rst_n), .cap(fire_ba), .src(b_in),
        .pick(pick_ba), .en(!to_a_en_n), .out_d(a_out), .out_oe(a_oe)
    );

    // R4: enable polarities
    p_drive_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
        to_b_en |=> b_oe);
    p_drive_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !to_a_en_n |=> a_oe);
    // R5: live path delivers the previous opposite-bus sample
    p_live_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (to_b_en && !pick_ab) |=> (b_out == ($past(a_in) ^ FLIP)));
    p_live_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!to_a_en_n && !pick_ba) |=> (a_out == ($past(b_in) ^ FLIP)));
endmodule

// File: tb/reg_xcvr_test.sv
`timescale 1ns/1ps
module reg_xcvr_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [7:0] ext_a = 8'h00, ext_b = 8'h00;
    logic ext_a_drv = 1'b1, ext_b_drv = 1'b1;
    logic cap_ab = 0, cap_ba = 0, to_b_en = 0, to_a_en_n = 1, pick_ab = 0, pick_ba = 0;
    logic [7:0] a_out, b_out, ia_out, ib_out, hold_a, hold_b;
    logic a_oe, b_oe, ia_oe, ib_oe;
    logic [7:0] bus_a, bus_b;

    // bus resolution model: external source wins, then the block, else last value
    assign bus_a = ext_a_drv ? ext_a : (a_oe ? a_out : hold_a);
    assign bus_b = ext_b_drv ? ext_b : (b_oe ? b_out : hold_b);
    always_ff @(posedge clk) begin
        hold_a <= bus_a;
        hold_b <= bus_b;
    end

    reg_xcvr uut (
        .clk(clk), .rst_n(rst_n), .a_in(bus_a), .a_out(a_out), .a_oe(a_oe),
        .b_in(bus_b), .b_out(b_out), .b_oe(b_oe), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .to_b_en(to_b_en), .to_a_en_n(to_a_en_n), .pick_ab(pick_ab), .pick_ba(pick_ba)
    );

    reg_xcvr #(.W(8), .INVERT(1'b1)) uut_inv (
        .clk(clk), .rst_n(rst_n), .a_in(bus_a), .a_out(ia_out), .a_oe(ia_oe),
        .b_in(bus_b), .b_out(ib_out), .b_oe(ib_oe), .cap_ab(cap_ab), .cap_ba(cap_ba),
        .to_b_en(to_b_en), .to_a_en_n(to_a_en_n), .pick_ab(pick_ab), .pick_ba(pick_ba)
    );

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 a_oe", {7'd0, a_oe}, 8'h00);
        chk("R1 b_oe", {7'd0, b_oe}, 8'h00);
        chk("R1 a_out", a_out, 8'h00);
        chk("R1 b_out", b_out, 8'h00);
        to_b_en = 1; to_a_en_n = 0; pick_ab = 1; pick_ba = 1;
        step();
        chk("R1 stored AB zero", b_out, 8'h00);
        chk("R1 stored BA zero", a_out, 8'h00);
        to_b_en = 0; to_a_en_n = 1; pick_ab = 0; pick_ba = 0;
        step();
    endtask

    task automatic t_capture_isolated;
        ext_a = 8'h5A; ext_b = 8'hC3; pick_ab = 1; pick_ba = 0;
        cap_ab = 1;
        step();
        cap_ab = 0; ext_a = 8'h00; pick_ba = 1;
        chk("R4 isolated b_oe", {7'd0, b_oe}, 8'h00);
        chk("R4 isolated b_out", b_out, 8'h00);
        cap_ba = 1;
        step();
        cap_ba = 0; ext_b = 8'h00;
        chk("R4 isolated a_out", a_out, 8'h00);
        chk("R4 isolated a_oe", {7'd0, a_oe}, 8'h00);
        to_b_en = 1; to_a_en_n = 0;
        step();
        chk("R4 b_oe active high", {7'd0, b_oe}, 8'h01);
        chk("R4 a_oe active low", {7'd0, a_oe}, 8'h01);
        chk("R3 R6 stored A on B", b_out, 8'h5A);
        chk("R3 R6 stored B on A", a_out, 8'hC3);
        chk("R8 inverted stored A", ib_out, 8'hA5);
    endtask

    task automatic t_strobe_held;
        ext_a = 8'h77; cap_ab = 1;
        step();
        ext_a = 8'h99;
        step(3);
        cap_ab = 0;
        chk("R2 held strobe captures once", b_out, 8'h77);
        step(2);
        chk("R2 no capture on fall", b_out, 8'h77);
    endtask

    task automatic t_live;
        pick_ab = 0; pick_ba = 0; ext_a = 8'h12; ext_b = 8'h34;
        step();
        chk("R5 live A to B", b_out, 8'h12);
        chk("R5 live B to A", a_out, 8'h34);
        ext_a = 8'hA0;
        step();
        chk("R5 live A to B follow", b_out, 8'hA0);
        chk("R8 inverted live", ib_out, 8'h5F);
    endtask

    task automatic t_select_switch;
        ext_a = 8'h11; pick_ab = 1;
        step();
        chk("R7 stored shown", b_out, 8'h77);
        pick_ab = 0;
        step();
        chk("R7 switch to live", b_out, 8'h11);
        pick_ab = 1;
        step();
        chk("R7 switch to stored", b_out, 8'h77);
    endtask

    task automatic t_both_edges;
        ext_a = 8'h21; ext_b = 8'h43; cap_ab = 1; cap_ba = 1;
        step();
        cap_ab = 0; cap_ba = 0; ext_a = 8'hEE; ext_b = 8'hDD;
        pick_ab = 1; pick_ba = 1;
        step();
        chk("R10 both AB", b_out, 8'h21);
        chk("R10 both BA", a_out, 8'h43);
    endtask

    task automatic t_loopback;
        pick_ab = 0; pick_ba = 0; ext_a = 8'h3C; ext_b_drv = 0;
        step(3);
        chk("R9 B follows A", bus_b, 8'h3C);
        ext_a_drv = 0;
        step(4);
        chk("R9 A held", bus_a, 8'h3C);
        chk("R9 B held", bus_b, 8'h3C);
        ext_a_drv = 1; ext_b_drv = 1;
    endtask

    initial begin
        step(3);
        rst_n = 1;
        step();
        t_reset();
        t_capture_isolated();
        t_strobe_held();
        t_live();
        t_select_switch();
        t_both_edges();
        t_loopback();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            vectors++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule